// File: doc/BRIEF.md
# Tree-Walking Prefix Code Decoder

This block turns a packed word of variable-length prefix code bits, such as Huffman-coded data, into a sequence of byte symbols. The code tree is supplied as a flat vector of flags, one per node, addressed heap style. The root is node 1, and the two children of node i are 2i and 2i+1. A node whose flag is set ends a code word, and the node index itself is the decoded symbol. Because of this, no separate symbol table is needed.

A start strobe loads the tree, the input word and the mode bit. From then on the block spends one clock cycle per tree step and consumes one input bit per step, least significant bit first. The highest set bit of the input word is a sentinel that marks where the valid data ends. When the walk stops, the block publishes four results together with a one-cycle done strobe:
- the output word, with symbols packed from byte 0 upward;
- the number of bytes written;
- the unconsumed input shifted down to bit 0, including any partial code word and the sentinel;
- an overflow flag.

Top module: `pcd_decoder`

States and transitions:
- `ST_IDLE` moves to `ST_WALK` on start. This is the *accept* transition.
- `ST_WALK` stays in `ST_WALK` while a step neither ends the walk nor hits a stop condition. This is the *step* transition.
- `ST_WALK` returns to `ST_IDLE` on any stop condition. This is the *finish* transition, and it raises done. The stop conditions are:
  - only the sentinel (or nothing) is left;
  - a symbol was emitted in single mode;
  - the output word is full;
  - six bits were walked without reaching a set flag.

## Requirements
- R1: Walking starts at node 1. Reading bit b at node i moves to node 2i+b. Reaching a node whose tree-vector bit is 1 completes a code word whose symbol is that node index (2 to 127). Tree bits 0 and 1 have no effect.
- R2: Input bits are consumed starting at bit 0 of the input word and moving upward.
- R3: Symbol k of an operation (k counted from 0) is written into bits 8k+7..8k of the output word, zero-extended. Unwritten bytes read 0, and the byte count gives the number of symbols. All results stay constant except in the cycle where done is high.
- R4: With the single bit set to 1, at most one symbol is decoded. The leftover then holds the input after that code word.
- R5: With the single bit set to 0, decoding continues code word after code word until a stop condition occurs.
- R6: The highest set bit of the input word is the end sentinel. When only the sentinel remains, or the input word is 0, decoding ends with overflow 0. The leftover is then the remaining bits including the sentinel (0 for an all-zero input).
- R7: If the input ends part-way through a code word, including after six unmatched bits with nothing but the sentinel left:
  - no symbol is emitted for it;
  - overflow stays 0;
  - the leftover is the input from the first bit of that code word.
- R8: If six bits are walked without reaching a set flag while more data bits remain, the block stops with overflow 1. Earlier symbols are kept, and the leftover is the input from the first bit of the failing code word.
- R9: Decoding stops once 8 symbols have been written. The leftover is the input after the eighth code word.
- R10: Done is high for exactly one cycle. Counting from the start edge, it comes after one cycle per consumed bit, plus one more cycle if the walk ended at the sentinel.
- R11: A start pulse while a walk is in progress is ignored, and the results are those of the operation already running.
- R12: After reset, done, overflow, byte count, output word and leftover are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| single | input | 1 | 1: decode at most one symbol; 0: decode until a stop condition |
| tree | input | 128 | Node flags; bit i set means node i ends a code word |
| bits_in | input | 64 | Packed code bits, LSB first, ended by a sentinel bit |
| done | output | 1 | One-cycle pulse when results are published |
| overflow | output | 1 | Code word longer than six bits was found |
| out_word | output | 64 | Decoded symbols, byte 0 first |
| rest_bits | output | 64 | Unconsumed input including sentinel, aligned to bit 0 |
| byte_count | output | 4 | Number of symbols written |

## Verification
No result is due at a fixed offset from start. The done pulse follows the start edge after one cycle per consumed bit, plus one cycle when the walk ends at the sentinel. The bench's reference function computes this count along with the expected symbols, leftover and overflow. The bench sets inputs on falling edges and counts falling edges after the start edge until done appears. It checks that the count matches the expected latency, reads all four results in that same half-cycle, and checks on the next falling edge that done has dropped.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } pcd_state_e;
endpackage

// File: rtl/pcd_step.sv
// One tree step: form the child index from the current node and the bit just read,
// look up its flag, and tell whether this step reaches the deepest allowed level.
module pcd_step #(
    parameter int MAX_DEPTH = 6,
    localparam int NODE_W   = MAX_DEPTH + 1,
    localparam int TREE_W   = 1 << NODE_W,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic [NODE_W-2:0]  node,
    input  logic               in_bit,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [TREE_W-1:0]  tree,
    output logic [NODE_W-1:0]  child,
    output logic               hit,
    output logic               at_limit
);
    always_comb begin
        child    = {node, in_bit};
        hit      = tree[child];
        at_limit = (depth == DEPTH_W'(MAX_DEPTH - 1));
    end
endmodule

// File: rtl/pcd_place.sv
// Replaces byte lane 'idx' of 'word_in' with 'sym'; other lanes pass through.
module pcd_place #(
    parameter int LANES  = 8,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES*BYTE_W-1:0] word_in,
    input  logic [IDX_W-1:0]        idx,
    input  logic [BYTE_W-1:0]       sym,
    output logic [LANES*BYTE_W-1:0] word_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (idx == IDX_W'(g)) begin
                word_out[g*BYTE_W +: BYTE_W] = sym;
            end else begin
                word_out[g*BYTE_W +: BYTE_W] = word_in[g*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/pcd_decoder.sv
module pcd_decoder #(
    parameter int MAX_DEPTH = 6,
    parameter int IN_W      = 64,
    parameter int OUT_BYTES = 8,
    localparam int BYTE_W   = 8,
    localparam int NODE_W   = MAX_DEPTH + 1,
    localparam int TREE_W   = 1 << NODE_W,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1),
    localparam int OUT_W    = OUT_BYTES * BYTE_W,
    localparam int IDX_W    = $clog2(OUT_BYTES),
    localparam int CNT_W    = $clog2(OUT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              single,
    input  logic [TREE_W-1:0] tree,
    input  logic [IN_W-1:0]   bits_in,
    output logic              done,
    output logic              overflow,
    output logic [OUT_W-1:0]  out_word,
    output logic [IN_W-1:0]   rest_bits,
    output logic [CNT_W-1:0]  byte_count
);
    import pcd_pkg::*;

    localparam logic [NODE_W-2:0] ROOT = (NODE_W-1)'(1);

    pcd_state_e state, state_nx;

    // Working registers of the walk
    logic [TREE_W-1:0]  tree_q;
    logic [IN_W-1:0]    rem_q;      // bits not yet read
    logic [IN_W-1:0]    cw_q;       // bits from the start of the current code word
    logic [NODE_W-2:0]  node_q;
    logic [DEPTH_W-1:0] depth_q;
    logic [OUT_W-1:0]   acc_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               single_q;

    // Published results
    logic               done_q;
    logic               ovf_q;
    logic [OUT_W-1:0]   out_q;
    logic [IN_W-1:0]    rest_q;
    logic [CNT_W-1:0]   cnt_out_q;

    // Step results
    logic [NODE_W-1:0]  child;
    logic               hit;
    logic               at_limit;
    logic [OUT_W-1:0]   placed;
    logic [IN_W-1:0]    rem_shift;
    logic               empty;
    logic               more_after;
    logic [CNT_W-1:0]   cnt_inc;
    logic               full_now;
    logic               busy;

    // Transition decisions
    logic               accept;
    logic               emit;
    logic               finish;
    logic               fin_ovf;
    logic [IN_W-1:0]    fin_rest;

    pcd_step #(.MAX_DEPTH(MAX_DEPTH)) u_step (
        .node     (node_q),
        .in_bit   (rem_q[0]),
        .depth    (depth_q),
        .tree     (tree_q),
        .child    (child),
        .hit      (hit),
        .at_limit (at_limit)
    );

    pcd_place #(.LANES(OUT_BYTES), .BYTE_W(BYTE_W)) u_place (
        .word_in  (acc_q),
        .idx      (cnt_q[IDX_W-1:0]),
        .sym      (BYTE_W'(child)),
        .word_out (placed)
    );

    always_comb begin
        rem_shift  = rem_q >> 1;
        empty      = (rem_q[IN_W-1:1] == '0);
        more_after = (rem_q[IN_W-1:2] != '0);
        cnt_inc    = cnt_q + CNT_W'(1);
        full_now   = (cnt_inc == CNT_W'(OUT_BYTES));
        busy       = (state == ST_WALK);
    end

    // Next-state and transition decisions
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        emit     = 1'b0;
        finish   = 1'b0;
        fin_ovf  = 1'b0;
        fin_rest = cw_q;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    accept   = 1'b1;
                    state_nx = ST_WALK;
                end
            end
            ST_WALK: begin
                if (empty) begin
                    finish = 1'b1;
                end else if (hit) begin
                    emit = 1'b1;
                    if (single_q || full_now) begin
                        finish   = 1'b1;
                        fin_rest = rem_shift;
                    end
                end else if (at_limit) begin
                    finish  = 1'b1;
                    fin_ovf = more_after;
                end
                if (finish) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tree_q    <= '0;
            rem_q     <= '0;
            cw_q      <= '0;
            node_q    <= ROOT;
            depth_q   <= '0;
            acc_q     <= '0;
            cnt_q     <= '0;
            single_q  <= 1'b0;
            done_q    <= 1'b0;
            ovf_q     <= 1'b0;
            out_q     <= '0;
            rest_q    <= '0;
            cnt_out_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                tree_q   <= tree;
                rem_q    <= bits_in;
                cw_q     <= bits_in;
                node_q   <= ROOT;
                depth_q  <= '0;
                acc_q    <= '0;
                cnt_q    <= '0;
                single_q <= single;
            end else if (busy && !empty) begin
                rem_q <= rem_shift;
                if (emit) begin
                    acc_q   <= placed;
                    cnt_q   <= cnt_inc;
                    node_q  <= ROOT;
                    depth_q <= '0;
                    cw_q    <= rem_shift;
                end else begin
                    node_q  <= child[NODE_W-2:0];
                    depth_q <= depth_q + DEPTH_W'(1);
                end
            end
            if (finish) begin
                done_q    <= 1'b1;
                ovf_q     <= fin_ovf;
                rest_q    <= fin_rest;
                cnt_out_q <= emit ? cnt_inc : cnt_q;
                out_q     <= emit ? placed : acc_q;
            end
        end
    end

    assign done       = done_q;
    assign overflow   = ovf_q;
    assign out_word   = out_q;
    assign rest_bits  = rest_q;
    assign byte_count = cnt_out_q;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
    parameter int IN_W      = 64,
    parameter int OUT_BYTES = 8,
    localparam int OUT_W    = OUT_BYTES * 8,
    localparam int CNT_W    = $clog2(OUT_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             single_q,
    input logic             done,
    input logic             overflow,
    input logic [OUT_W-1:0] out_word,
    input logic [IN_W-1:0]  rest_bits,
    input logic [CNT_W-1:0] byte_count
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_results_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(out_word) && $stable(rest_bits)
                   && $stable(byte_count) && $stable(overflow)));

    assert_count_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_count <= CNT_W'(OUT_BYTES));

    assert_single_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && single_q) |-> (byte_count <= CNT_W'(1)));

    assert_no_overflow_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (byte_count < CNT_W'(OUT_BYTES)));

    assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(single_q));
endmodule

bind pcd_decoder pcd_checker #(.IN_W(IN_W), .OUT_BYTES(OUT_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .single_q   (single_q),
    .done       (done),
    .overflow   (overflow),
    .out_word   (out_word),
    .rest_bits  (rest_bits),
    .byte_count (byte_count)
);

// File: tb/sim_pcd_decoder.sv
`timescale 1ns/1ps
module sim_pcd_decoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         single = 1'b0;
    logic [127:0] tree = '0;
    logic [63:0]  bits_in = '0;
    logic         done;
    logic         overflow;
    logic [63:0]  out_word;
    logic [63:0]  rest_bits;
    logic [3:0]   byte_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pcd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .single(single),
        .tree(tree), .bits_in(bits_in), .done(done), .overflow(overflow),
        .out_word(out_word), .rest_bits(rest_bits), .byte_count(byte_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference walk built from the requirements
    function automatic void model(input logic [127:0] t, input logic [63:0] x, input bit one,
                                  output logic [63:0] o, output logic [63:0] r,
                                  output bit ov, output int n, output int cyc);
        logic [63:0] rem = x;
        logic [63:0] cw  = x;
        int node = 1;
        int depth = 0;
        bit fin = 0;
        o = '0; r = '0; ov = 0; n = 0; cyc = 0;
        while (!fin) begin
            cyc++;
            if (rem <= 64'd1) begin
                r = cw; fin = 1;
            end else begin
                node = node * 2 + int'(rem[0]);
                rem = rem >> 1;
                depth++;
                if (t[node]) begin
                    o[n*8 +: 8] = 8'(node);
                    n++;
                    if (one || n == 8) begin
                        r = rem; fin = 1;
                    end else begin
                        node = 1; depth = 0; cw = rem;
                    end
                end else if (depth == 6) begin
                    ov = (rem > 64'd1); r = cw; fin = 1;
                end
            end
        end
    endfunction

    task automatic run(input logic [127:0] t, input logic [63:0] x, input bit one, input bit inject);
        logic [63:0] eo, er;
        bit eov;
        int en, ecyc;
        int lat = 0;
        model(t, x, one, eo, er, eov, en, ecyc);
        @(negedge clk);
        tree = t; bits_in = x; single = one; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (done) break;
            if (inject && lat == 1) begin
                // R11: start with different data while walking
                tree = ~t; bits_in = ~x; single = ~one; start = 1'b1;
            end
            if (lat > 200) begin
                checks++; errors++;
                $display("FAIL R10 watchdog: no done actual=0 expected=1");
                return;
            end
        end
        chk(inject ? "R11 latency" : "R10 latency", 64'(lat), 64'(ecyc));
        chk("R1 R2 R3 R5 output word", out_word, eo);
        chk("R4 R6 R7 R9 leftover", rest_bits, er);
        chk("R8 overflow", 64'(overflow), 64'(eov));
        chk("R3 byte count", 64'(byte_count), 64'(en));
        @(negedge clk);
        chk("R10 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] t2;
        logic [127:0] t3;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 done", 64'(done), 64'd0);
        chk("R12 overflow", 64'(overflow), 64'd0);
        chk("R12 out_word", out_word, 64'd0);
        chk("R12 rest_bits", rest_bits, 64'd0);
        chk("R12 byte_count", 64'(byte_count), 64'd0);

        t2 = 128'b1100;   // nodes 2 ("0") and 3 ("1")
        t3 = 128'b0100;   // node 2 only
        // R1 R2 R5: bits 0,1,1,0 then sentinel -> symbols 2,3,3,2
        run(t2, 64'b1_0110, 1'b0, 1'b0);
        chk("R2 hand symbols", out_word, 64'h02030302);
        // R4 single mode
        run(t2, 64'b1_0110, 1'b1, 1'b0);
        chk("R4 hand leftover", rest_bits, 64'b1011);
        // R6 empty inputs
        run(t2, 64'd0, 1'b0, 1'b0);
        run(t2, 64'd1, 1'b0, 1'b0);
        // R8 overflow after one symbol
        run(t3, 64'h1FE, 1'b0, 1'b0);
        chk("R8 hand overflow", 64'(overflow), 64'd1);
        chk("R8 hand leftover", rest_bits, 64'hFF);
        // R7 truncated code word
        run(t3, 64'b1110, 1'b0, 1'b0);
        chk("R7 hand leftover", rest_bits, 64'b111);
        // R7 six unmatched bits then only sentinel
        run(t3, 64'b1_111111_0, 1'b0, 1'b0);
        chk("R7 no overflow", 64'(overflow), 64'd0);
        // R9 full output
        run(t2, 64'h7A5, 1'b0, 1'b0);
        chk("R9 hand count", 64'(byte_count), 64'd8);
        // R1 tree bits 0 and 1 ignored
        run(128'b1111, 64'b1_0110, 1'b0, 1'b0);
        // R11 busy start ignored
        run(t2, 64'b1_0110, 1'b0, 1'b1);

        for (int i = 0; i < 300; i++) begin
            logic [127:0] t;
            logic [63:0] x;
            int len;
            int dens;
            t = {$urandom, $urandom, $urandom, $urandom};
            dens = $urandom_range(0, 2);
            for (int d = 0; d < dens; d++) t = t & {$urandom, $urandom, $urandom, $urandom};
            len = $urandom_range(0, 63);
            x = {$urandom, $urandom};
            x = (x & ((64'd1 << len) - 64'd1)) | (64'd1 << len);
            run(t, x, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule